// File: doc/BRIEF.md
# Two-Channel Digitizer Acquisition Sequencer

This block runs one acquisition cycle of a deflection-plane digitizer each time it is asked to. It strobes the vertical track-and-hold first and the horizontal track-and-hold (together with the beam-blanking flag) a fixed number of clocks later. It then routes the two held voltages one after the other to a single successive-approximation converter. The converter is built from an external DAC and comparator, and this block drives the search.

The vertical result is the data word. The horizontal result, with a 2-bit waveform slot code above it, is the write address. A waveform is therefore filled point by point at whatever horizontal position the beam was on, in any order, over as many sweeps as it takes. The most recent vertical result is always visible on a host read port. A system timer is expected to pulse the start input at the fixed sample interval (6.5 us in the intended system).

Top module: `acq_sequencer`

## Requirements
- R1: After reset, busy, done, both hold strobes and the memory write enable are low, and the host sample port reads 0.
- R2: A start pulse seen while idle raises the vertical hold strobe for exactly one cycle in the next clock cycle. The horizontal hold strobe follows for one cycle exactly HOLD_GAP cycles after the vertical one (HOLD_GAP is at least 2).
- R3: In the cycle after the horizontal hold, the channel select goes to 0 (vertical) for V_W cycles, then to 1 (horizontal) for H_W cycles.
- R4: Each conversion tests one bit per clock, MSB first. The DAC code in a step is the bits kept so far plus the bit under test. The bit is kept when the comparator input is 1 (held level at or above the DAC code). The first vertical trial is therefore 2^(V_W-1), and the first horizontal trial is 2^(H_W-1). Horizontal trials occupy the low H_W bits of the DAC code.
- R5: In the cycle after the horizontal conversion, the write address is slot*2^H_W + horizontal code and the write data is the vertical code. Each point is written wherever its horizontal code points, whatever order the codes arrive in.
- R6: The write enable pulses for that one cycle only if the blanking input was 1 (beam visible) in the horizontal hold cycle. Otherwise no write occurs.
- R7: The host sample port changes only at the end of a vertical conversion and then shows that code, whether or not the point is written.
- R8: Busy is high from the vertical hold cycle through the final cycle of the acquisition cycle. Done is high in that final cycle only, and busy is low in the cycle after.
- R9: A start pulse that arrives while busy has no effect on the strobes, the timing or the slot of the running cycle.
- R10: The slot code is taken when the start is accepted. Later changes on the slot input do not move the write address of that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an acquisition cycle |
| slot_sel | input | 2 | Waveform slot code for the next cycle |
| unblank | input | 1 | 1 when the beam is visible, sampled at horizontal hold |
| cmp_in | input | 1 | Comparator: 1 when held level is at or above the DAC code |
| hold_v | output | 1 | Vertical hold strobe |
| hold_h | output | 1 | Horizontal hold strobe |
| mux_sel | output | 1 | Converter input select, 0 vertical, 1 horizontal |
| dac_code | output | 10 | Trial code to the DAC |
| mem_addr | output | 11 | Waveform memory write address |
| mem_data | output | 10 | Waveform memory write data |
| mem_we | output | 1 | Waveform memory write enable |
| host_vsample | output | 10 | Latest vertical conversion result |
| busy | output | 1 | Acquisition cycle in progress |
| done | output | 1 | One-cycle end-of-cycle marker |

## Verification
The held levels are driven at both extremes (all zeros, full scale) and with alternating bit patterns. These show whether every bit position is decided independently and in MSB-first order. A run of points with falling horizontal codes in one slot, and the same codes in another slot, separates address-follows-code behaviour from any counter-based addressing. It also shows whether the slot bits are placed correctly. A blanked point shows that the host register still updates while memory stays untouched. Start pulses inside a running cycle, and a start held high across a whole cycle, show that requests are dropped while busy and taken again once idle.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int V_W_DEF    = 10;
    localparam int H_W_DEF    = 9;
    localparam int SLOT_W_DEF = 2;
    localparam int GAP_DEF    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_V,
        ST_GAP,
        ST_HOLD_H,
        ST_CONV_V,
        ST_CONV_H,
        ST_WRITE
    } acq_state_e;

    typedef struct packed {
        logic hold_v;
        logic hold_h;
        logic conv_v;
        logic conv_h;
        logic commit;
    } phase_t;

    function automatic phase_t decode_phase(acq_state_e s);
        phase_t p;
        p.hold_v = (s == ST_HOLD_V);
        p.hold_h = (s == ST_HOLD_H);
        p.conv_v = (s == ST_CONV_V);
        p.conv_h = (s == ST_CONV_H);
        p.commit = (s == ST_WRITE);
        return p;
    endfunction

endpackage

// File: rtl/acq_timing.sv
module acq_timing
    import acq_pkg::*;
#(
    parameter int HOLD_GAP = GAP_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   sar_last,
    output phase_t ph,
    output logic   take,
    output logic   busy
);
    localparam int CW = $clog2(HOLD_GAP + 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(HOLD_GAP - 2);

    acq_state_e        state;
    logic [CW-1:0]     gap_cnt;

    assign ph   = decode_phase(state);
    assign busy = (state != ST_IDLE);
    assign take = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            gap_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE:   if (start) state <= ST_HOLD_V;
                ST_HOLD_V: begin
                    state   <= ST_GAP;
                    gap_cnt <= GAP_LOAD;
                end
                ST_GAP: begin
                    if (gap_cnt == '0) state <= ST_HOLD_H;
                    else               gap_cnt <= gap_cnt - 1'b1;
                end
                ST_HOLD_H: state <= ST_CONV_V;
                ST_CONV_V: if (sar_last) state <= ST_CONV_H;
                ST_CONV_H: if (sar_last) state <= ST_WRITE;
                ST_WRITE:  state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    AST_HOLD_V_PULSE: assert property (@(posedge clk) disable iff (rst)
        ph.hold_v |=> !ph.hold_v && busy);                    // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !ph.commit) |=> busy);                       // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        ph.commit |=> !busy);                                 // R8
    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        take |=> ph.hold_v);                                  // R2

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  init,
    input  logic [$clog2(W)-1:0]  init_idx,
    input  logic                  cmp,
    output logic [W-1:0]          trial,
    output logic [W-1:0]          resolved,
    output logic                  last
);
    localparam int IW = $clog2(W);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0]  acc;
    logic [IW-1:0] idx;
    logic          active;
    logic [W-1:0]  probe;

    assign probe    = active ? (ONE << idx) : '0;
    assign trial    = acc | probe;
    assign resolved = cmp ? trial : acc;
    assign last     = active && (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            idx    <= '0;
            active <= 1'b0;
        end else if (init) begin
            acc    <= '0;
            idx    <= init_idx;
            active <= 1'b1;
        end else if (active) begin
            acc <= resolved;
            if (idx == '0) active <= 1'b0;
            else           idx    <= idx - 1'b1;
        end
    end

    AST_SAR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (active && !last && !init && cmp) |=> ((acc & $past(trial)) == $past(trial))); // R4
    AST_SAR_DROP: assert property (@(posedge clk) disable iff (rst)
        (active && !last && !init && !cmp) |=> ((acc & $past(probe)) == '0));          // R4

endmodule

// File: rtl/acq_store.sv
module acq_store #(
    parameter int V_W    = 10,
    parameter int H_W    = 9,
    parameter int SLOT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   take,
    input  logic [SLOT_W-1:0]      slot_in,
    input  logic                   hold_h,
    input  logic                   unblank,
    input  logic                   v_done,
    input  logic                   h_done,
    input  logic                   commit,
    input  logic [V_W-1:0]         resolved,
    output logic [SLOT_W+H_W-1:0]  mem_addr,
    output logic [V_W-1:0]         mem_data,
    output logic                   mem_we,
    output logic [V_W-1:0]         host_v
);
    logic [SLOT_W-1:0] slot_q;
    logic [H_W-1:0]    hcode;
    logic [V_W-1:0]    vcode;
    logic              ub_q;

    assign mem_addr = {slot_q, hcode};
    assign mem_data = vcode;
    assign mem_we   = commit && ub_q;
    assign host_v   = vcode;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            hcode  <= '0;
            vcode  <= '0;
            ub_q   <= 1'b0;
        end else begin
            if (take)   slot_q <= slot_in;
            if (hold_h) ub_q   <= unblank;
            if (v_done) vcode  <= resolved;
            if (h_done) hcode  <= resolved[H_W-1:0];
        end
    end

    AST_HOST_STABLE: assert property (@(posedge clk) disable iff (rst)
        !v_done |=> $stable(host_v));                 // R7
    AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(slot_q));                   // R10
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);                          // R6

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int V_W      = V_W_DEF,
    parameter int H_W      = H_W_DEF,
    parameter int SLOT_W   = SLOT_W_DEF,
    parameter int HOLD_GAP = GAP_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [SLOT_W-1:0]      slot_sel,
    input  logic                   unblank,
    input  logic                   cmp_in,
    output logic                   hold_v,
    output logic                   hold_h,
    output logic                   mux_sel,
    output logic [V_W-1:0]         dac_code,
    output logic [SLOT_W+H_W-1:0]  mem_addr,
    output logic [V_W-1:0]         mem_data,
    output logic                   mem_we,
    output logic [V_W-1:0]         host_vsample,
    output logic                   busy,
    output logic                   done
);
    localparam int IW = $clog2(V_W);
    localparam logic [IW-1:0] V_MSB = IW'(V_W - 1);
    localparam logic [IW-1:0] H_MSB = IW'(H_W - 1);

    phase_t          ph;
    logic            take;
    logic            sar_last;
    logic            sar_init;
    logic [IW-1:0]   sar_idx;
    logic [V_W-1:0]  trial;
    logic [V_W-1:0]  resolved;

    acq_timing #(.HOLD_GAP(HOLD_GAP)) u_timing (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sar_last (sar_last),
        .ph       (ph),
        .take     (take),
        .busy     (busy)
    );

    assign sar_init = ph.hold_h || (ph.conv_v && sar_last);
    assign sar_idx  = ph.hold_h ? V_MSB : H_MSB;

    sar_engine #(.W(V_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .init     (sar_init),
        .init_idx (sar_idx),
        .cmp      (cmp_in),
        .trial    (trial),
        .resolved (resolved),
        .last     (sar_last)
    );

    acq_store #(.V_W(V_W), .H_W(H_W), .SLOT_W(SLOT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .slot_in  (slot_sel),
        .hold_h   (ph.hold_h),
        .unblank  (unblank),
        .v_done   (ph.conv_v && sar_last),
        .h_done   (ph.conv_h && sar_last),
        .commit   (ph.commit),
        .resolved (resolved),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .mem_we   (mem_we),
        .host_v   (host_vsample)
    );

    assign hold_v   = ph.hold_v;
    assign hold_h   = ph.hold_h;
    assign mux_sel  = ph.conv_h;
    assign dac_code = trial;
    assign done     = ph.commit;

    AST_MUX_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold_h |=> (!mux_sel && busy));                         // R3
    AST_WE_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (done && busy));                             // R6
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hold_v, hold_h, done}));                      // R2

endmodule

// File: tb/test_acq_sequencer.sv
module test_acq_sequencer;
    localparam int V_W = 10;
    localparam int H_W = 9;
    localparam int G   = 5;
    localparam int LAST = G + V_W + H_W + 1;
    localparam int PERIOD = 325;

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [1:0] slot_sel = 0;
    logic unblank = 0;
    logic cmp_in;
    logic hold_v, hold_h, mux_sel, mem_we, busy, done;
    logic [V_W-1:0] dac_code, mem_data, host_vsample;
    logic [10:0] mem_addr;

    int v_an = 0, h_an = 0, v_held = 0, h_held = 0;
    int tests = 0, fails = 0, cycles = 0;
    int ref_t = -1, ref_slot = 0, ref_v = 0, ref_h = 0, ref_host = 0;
    bit ref_ub = 0;
    int mem_model [0:2047];

    always #10 clk = ~clk;

    acq_sequencer i_acq_sequencer (
        .clk(clk), .rst(rst), .start(start), .slot_sel(slot_sel),
        .unblank(unblank), .cmp_in(cmp_in), .hold_v(hold_v), .hold_h(hold_h),
        .mux_sel(mux_sel), .dac_code(dac_code), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_we(mem_we), .host_vsample(host_vsample),
        .busy(busy), .done(done)
    );

    // analog side: held levels and comparator
    assign cmp_in = mux_sel ? (h_held >= int'(dac_code)) : (v_held >= int'(dac_code));

    always @(posedge clk) begin
        if (hold_v) v_held <= v_an;
        if (hold_h) h_held <= h_an;
        if (mem_we) mem_model[int'(mem_addr)] <= int'(mem_data);
    end

    // behavioural reference: cycle position inside an acquisition
    always @(posedge clk) begin
        if (rst) begin
            ref_t <= -1; ref_host <= 0;
        end else begin
            if (ref_t < 0) begin
                if (start) begin
                    ref_t <= 0; ref_slot <= int'(slot_sel);
                    ref_v <= v_an; ref_h <= h_an;
                end
            end else if (ref_t == LAST) ref_t <= -1;
            else ref_t <= ref_t + 1;
            if (ref_t == G) ref_ub <= unblank;
            if (ref_t == G + V_W) ref_host <= ref_v;
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R2 hold_v", int'(hold_v), int'(ref_t == 0));
            check("R2 hold_h", int'(hold_h), int'(ref_t == G));
            check("R3 mux_sel", int'(mux_sel), int'(ref_t > G + V_W && ref_t < LAST));
            check("R8 busy", int'(busy), int'(ref_t >= 0));
            check("R8 done", int'(done), int'(ref_t == LAST));
            check("R6 mem_we", int'(mem_we), int'(ref_t == LAST && ref_ub));
            check("R7 host", int'(host_vsample), ref_host);
            if (ref_t == G + 1) check("R4 first V trial", int'(dac_code), 512);
            if (ref_t == G + V_W + 1) check("R4 first H trial", int'(dac_code), 256);
            if (ref_t == LAST && ref_ub) begin
                check("R5 addr", int'(mem_addr), ref_slot * 512 + ref_h);
                check("R5 data", int'(mem_data), ref_v);
                check("R10 slot", int'(mem_addr) / 512, ref_slot);
            end
        end
    end

    task automatic sample(int s, int v, int h, bit ub);
        @(negedge clk);
        slot_sel = 2'(s); v_an = v; h_an = h; unblank = ub; start = 1;
        @(negedge clk);
        start = 0;
        repeat (PERIOD - 2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem_model[i] = -1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 hold", int'(hold_v | hold_h), 0);
        check("R1 we", int'(mem_we | done), 0);
        check("R1 host", int'(host_vsample), 0);

        sample(0, 0, 0, 1);
        sample(1, 1023, 511, 1);
        sample(2, 682, 300, 1);
        sample(2, 341, 171, 1);
        // falling horizontal codes: address follows code
        sample(3, 100, 400, 1);
        sample(3, 200, 200, 1);
        sample(3, 300, 100, 1);
        sample(1, 555, 200, 1);
        // blanked point: host updates, no write
        sample(0, 777, 50, 0);

        // start pulses while busy and slot change mid-cycle (R9, R10)
        @(negedge clk);
        slot_sel = 2'd2; v_an = 444; h_an = 333; unblank = 1; start = 1;
        @(negedge clk); start = 0;
        repeat (6) @(negedge clk);
        slot_sel = 2'd1; start = 1;
        @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        start = 1;
        @(negedge clk); start = 0;
        repeat (60) @(negedge clk);
        check("R9 one cycle only", mem_model[1*512 + 333], -1);

        // start held high: re-accepted only after returning idle
        slot_sel = 2'd0; v_an = 12; h_an = 34; unblank = 1; start = 1;
        repeat (2 * (LAST + 2)) @(negedge clk);
        start = 0;
        repeat (60) @(negedge clk);

        check("R5 slot0 h0", mem_model[0], 0);
        check("R5 slot1 h511", mem_model[1023], 1023);
        check("R5 slot2 h300", mem_model[2*512 + 300], 682);
        check("R5 slot3 h400", mem_model[3*512 + 400], 100);
        check("R5 slot3 h200", mem_model[3*512 + 200], 200);
        check("R5 slot3 h100", mem_model[3*512 + 100], 300);
        check("R5 slot1 h200", mem_model[1*512 + 200], 555);
        check("R6 blanked", mem_model[50], -1);
        check("R10 kept slot", mem_model[2*512 + 333], 444);
        check("R2 held start", mem_model[34], 12);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule